// File: doc/BRIEF.md
# Dual-Channel Serial Command Loader with Double-Buffered Registers

This block takes 16-bit command words from a three-wire serial port (active-low select, serial clock, serial data) and keeps two channels of double-buffered 12-bit values. Each channel has a staging register and an output register. When the select line returns high, the captured word is decoded. Depending on the decoded command, the block fills a staging register, copies staging registers into output registers, or does both in one step. The block also holds a single user-controlled output pin and a one-bit output-edge mode flag. The two output-register values drive a converter elsewhere on the chip.

The serial pins and the clear input are oversampled in the system clock domain. The serial clock is never used as a clock. A frame is acted on only if exactly 16 serial clock rising edges arrived while the select line was low.

Top module: `serial_dual_reg_loader`

## Requirements
- R1: A frame is 16 bits, most significant bit first. Bit 15 is the channel bit K, bits 14 and 13 are the control bits M1 and M0, bits 12 down to 1 are the 12-bit value (first bit received is its MSB), and bit 0 is a trailing filler bit whose value is not used.
- R2: Data is captured on each synchronized rising edge of the serial clock while the select line is low. Serial clock and data activity while the select line is high changes nothing and does not disturb the bit count of the next frame.
- R3: {K,M1,M0} = 001 loads the value into staging A, and 101 loads it into staging B. Neither output register changes.
- R4: {K,M1,M0} = 010 loads staging A and 110 loads staging B. After either command, each output register holds its own channel's staging value, including the newly loaded one.
- R5: {K,M1,M0} = 011 writes the value straight into both output registers and leaves both staging registers unchanged.
- R6: {K,M1,M0} = 100 copies staging A to output A and staging B to output B.
- R7: With {K,M1,M0} = 000, value bits 11..8 are a sub-command. 001x copies staging A to output A only, and 101x copies staging B to output B only.
- R8: Sub-command 010x drives the user pin low and 011x drives it high. 1001 sets the edge-mode flag to 1 and 1000 clears it to 0. 000x, every other sub-command and the prefix 111 change nothing.
- R9: While the synchronized clear input is low, all four data registers are zero. Clear takes priority over a command in the same cycle and does not change the user pin or the edge-mode flag.
- R10: After reset, all four data registers are zero, the user pin is low and the edge-mode flag is 0.
- R11: If the select line rises after any count of serial clock edges other than 16, for example 15 or 17, the frame is discarded and no register changes.
- R12: A command's effect shows on the outputs at the third system clock rising edge after the select line rises, and a clear's effect at the third edge after clear goes low. This holds with the default of two synchronizer stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| clr_n | input | 1 | Active-low clear of the data registers |
| ser_clk | input | 1 | Serial clock, oversampled |
| ser_csn | input | 1 | Active-low serial select |
| ser_din | input | 1 | Serial data |
| chan_a_o | output | 12 | Output register of channel A |
| chan_b_o | output | 12 | Output register of channel B |
| user_pin_o | output | 1 | User-controlled output pin |
| edge_mode_o | output | 1 | Output-edge mode flag |

## Verification
Every result is due at the third system clock rising edge after the select line or the clear input changes: two synchronizer edges, then the register update. The reference model in the bench therefore delays each commit or clear event through a two-deep pipeline before applying it at the following edge. It compares all outputs at every falling edge, so it checks the exact cycle and not only the final value. A dedicated latency check samples the outputs two and three falling edges after the select line rises. It expects the old value at the first sample and the new value at the second. The named checks are taken only after each frame has had eight idle cycles to settle.

// File: rtl/scd_pkg.sv
package scd_pkg;

    localparam int PFX_W = 3;
    localparam int SUB_W = 4;

    typedef enum logic [PFX_W-1:0] {
        PFX_CTRL   = 3'b000,
        PFX_LD_A   = 3'b001,
        PFX_LDUP_A = 3'b010,
        PFX_DIRECT = 3'b011,
        PFX_XFER   = 3'b100,
        PFX_LD_B   = 3'b101,
        PFX_LDUP_B = 3'b110,
        PFX_SPARE  = 3'b111
    } prefix_e;

    typedef enum logic [2:0] {
        SUB_NOP,
        SUB_XFER_A,
        SUB_XFER_B,
        SUB_PIN_LO,
        SUB_PIN_HI,
        SUB_MODE_1,
        SUB_MODE_0
    } sub_e;

    function automatic sub_e decode_sub(input logic [SUB_W-1:0] code);
        sub_e r;
        casez (code)
            4'b001?: r = SUB_XFER_A;
            4'b101?: r = SUB_XFER_B;
            4'b010?: r = SUB_PIN_LO;
            4'b011?: r = SUB_PIN_HI;
            4'b1001: r = SUB_MODE_1;
            4'b1000: r = SUB_MODE_0;
            default: r = SUB_NOP;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/scd_sync.sv
module scd_sync #(
    parameter int               WIDTH   = 4,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stg_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= RST_VAL;
                else        stg_q[g] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= RST_VAL;
                else        stg_q[g] <= stg_q[g-1];
            end
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/scd_frame_rx.sv
module scd_frame_rx #(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_i,
    input  logic               csn_i,
    input  logic               din_i,
    output logic               commit_o,
    output logic [FRAME_W-1:1] word_o
);

    localparam int CNT_MAX = FRAME_W + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        logic               sclk_prev;
        logic               csn_prev;
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] sh;
    } rx_t;

    rx_t  rx_d, rx_q;
    logic sclk_rise;
    logic cs_rise;

    always_comb begin
        rx_d           = rx_q;
        rx_d.sclk_prev = sclk_i;
        rx_d.csn_prev  = csn_i;
        sclk_rise      = sclk_i & ~rx_q.sclk_prev;
        cs_rise        = csn_i & ~rx_q.csn_prev;
        if (csn_i) begin
            rx_d.cnt = '0;
        end else if (sclk_rise) begin
            rx_d.sh = {rx_q.sh[FRAME_W-2:0], din_i};
            if (rx_q.cnt != CNT_W'(CNT_MAX))
                rx_d.cnt = rx_q.cnt + CNT_W'(1);
        end
        commit_o = cs_rise && (rx_q.cnt == CNT_W'(FRAME_W));
        word_o   = rx_q.sh[FRAME_W-1:1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q.sclk_prev <= 1'b0;
            rx_q.csn_prev  <= 1'b1;
            rx_q.cnt       <= '0;
            rx_q.sh        <= '0;
        end else begin
            rx_q <= rx_d;
        end
    end

    // R2: with select high the count restarts for the next frame
    a_r2_idle_count_zero: assert property (@(posedge clk) disable iff (!rst_n)
        csn_i |=> (rx_q.cnt == '0));

    // R2: with select high no bit enters the shift register
    a_r2_idle_shift_hold: assert property (@(posedge clk) disable iff (!rst_n)
        csn_i |=> $stable(rx_q.sh));

endmodule

// File: rtl/scd_cmd_exec.sv
module scd_cmd_exec
    import scd_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr_i,
    input  logic                commit_i,
    input  logic [DATA_W+2:0]   word_i,
    output logic [DATA_W-1:0]   out_a_o,
    output logic [DATA_W-1:0]   out_b_o,
    output logic                pin_o,
    output logic                mode_o
);

    typedef struct packed {
        logic [1:0][DATA_W-1:0] stg;
        logic [1:0][DATA_W-1:0] outr;
        logic                   pin;
        logic                   mode;
    } ex_t;

    ex_t               ex_d, ex_q;
    prefix_e           pfx;
    logic [DATA_W-1:0] val;
    sub_e              sub;

    always_comb begin
        pfx  = prefix_e'(word_i[DATA_W+2 -: PFX_W]);
        val  = word_i[DATA_W-1:0];
        sub  = decode_sub(val[DATA_W-1 -: SUB_W]);
        ex_d = ex_q;
        if (clr_i) begin
            ex_d.stg  = '0;
            ex_d.outr = '0;
        end else if (commit_i) begin
            case (pfx)
                PFX_LD_A: ex_d.stg[0] = val;
                PFX_LD_B: ex_d.stg[1] = val;
                PFX_LDUP_A: begin
                    ex_d.stg[0]  = val;
                    ex_d.outr[0] = val;
                    ex_d.outr[1] = ex_q.stg[1];
                end
                PFX_LDUP_B: begin
                    ex_d.stg[1]  = val;
                    ex_d.outr[1] = val;
                    ex_d.outr[0] = ex_q.stg[0];
                end
                PFX_DIRECT: begin
                    ex_d.outr[0] = val;
                    ex_d.outr[1] = val;
                end
                PFX_XFER: ex_d.outr = ex_q.stg;
                PFX_CTRL: begin
                    case (sub)
                        SUB_XFER_A: ex_d.outr[0] = ex_q.stg[0];
                        SUB_XFER_B: ex_d.outr[1] = ex_q.stg[1];
                        SUB_PIN_LO: ex_d.pin     = 1'b0;
                        SUB_PIN_HI: ex_d.pin     = 1'b1;
                        SUB_MODE_1: ex_d.mode    = 1'b1;
                        SUB_MODE_0: ex_d.mode    = 1'b0;
                        default:    ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ex_q <= '0;
        else        ex_q <= ex_d;
    end

    assign out_a_o = ex_q.outr[0];
    assign out_b_o = ex_q.outr[1];
    assign pin_o   = ex_q.pin;
    assign mode_o  = ex_q.mode;

    // R3: staging-only loads leave both outputs alone
    a_r3_stage_only_keeps_out: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && !clr_i && (pfx == PFX_LD_A || pfx == PFX_LD_B)) |=> $stable(ex_q.outr));

    // R4: load A with update takes the new value and the old staging B
    a_r4_load_update_a: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && !clr_i && pfx == PFX_LDUP_A) |=>
        (ex_q.outr[0] == $past(val)) && (ex_q.outr[1] == $past(ex_q.stg[1])));

    // R6: transfer copies staging into outputs
    a_r6_transfer: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && !clr_i && pfx == PFX_XFER) |=> (ex_q.outr == $past(ex_q.stg)));

    // R9: clear zeroes every data register
    a_r9_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (ex_q.stg == '0) && (ex_q.outr == '0));

    // R8: pin and mode change only on a committed frame
    a_r8_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(ex_q.pin) && $stable(ex_q.mode));

    // R11: without commit or clear the data registers hold
    a_r11_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit_i && !clr_i) |=> $stable(ex_q.stg) && $stable(ex_q.outr));

endmodule

// File: rtl/serial_dual_reg_loader.sv
module serial_dual_reg_loader #(
    parameter int DATA_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              ser_clk,
    input  logic              ser_csn,
    input  logic              ser_din,
    output logic [DATA_W-1:0] chan_a_o,
    output logic [DATA_W-1:0] chan_b_o,
    output logic              user_pin_o,
    output logic              edge_mode_o
);

    localparam int FRAME_W = DATA_W + 4;
    localparam int N_SYNC  = 4;

    logic [N_SYNC-1:0] raw_w;
    logic [N_SYNC-1:0] syn_w;
    logic              commit_w;
    logic [FRAME_W-1:1] word_w;

    // bit order: clear, select, serial clock, serial data
    assign raw_w = {clr_n, ser_csn, ser_clk, ser_din};

    scd_sync #(
        .WIDTH   (N_SYNC),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b1100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_w),
        .q_o   (syn_w)
    );

    scd_frame_rx #(
        .FRAME_W (FRAME_W)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_i   (syn_w[1]),
        .csn_i    (syn_w[2]),
        .din_i    (syn_w[0]),
        .commit_o (commit_w),
        .word_o   (word_w)
    );

    scd_cmd_exec #(
        .DATA_W (DATA_W)
    ) u_exec (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (~syn_w[3]),
        .commit_i (commit_w),
        .word_i   (word_w),
        .out_a_o  (chan_a_o),
        .out_b_o  (chan_b_o),
        .pin_o    (user_pin_o),
        .mode_o   (edge_mode_o)
    );

endmodule

// File: tb/serial_dual_reg_loader_tb.sv
module serial_dual_reg_loader_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr_n = 1'b1;
    logic        ser_clk = 1'b0;
    logic        ser_csn = 1'b1;
    logic        ser_din = 1'b0;
    logic [11:0] chan_a_o, chan_b_o;
    logic        user_pin_o, edge_mode_o;

    int checks = 0;
    int failures = 0;
    bit started = 0;

    always #4 clk = ~clk;

    serial_dual_reg_loader u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_n       (clr_n),
        .ser_clk     (ser_clk),
        .ser_csn     (ser_csn),
        .ser_din     (ser_din),
        .chan_a_o    (chan_a_o),
        .chan_b_o    (chan_b_o),
        .user_pin_o  (user_pin_o),
        .edge_mode_o (edge_mode_o)
    );

    // reference model state
    logic [11:0] m_stg [2];
    logic [11:0] m_out [2];
    logic        m_pin, m_mode;
    bit          cur_commit = 0;
    logic [15:0] cur_word = '0;
    bit          e1_clr, e2_clr, e1_cm, e2_cm;
    logic [15:0] e1_w, e2_w;

    task automatic model_apply(input logic [15:0] w);
        logic [2:0]  p;
        logic [11:0] v;
        p = w[15:13];
        v = w[12:1];
        if (p == 3'd1) m_stg[0] = v;
        else if (p == 3'd5) m_stg[1] = v;
        else if (p == 3'd2 || p == 3'd6) begin
            m_stg[p[2]] = v;
            m_out[0] = m_stg[0];
            m_out[1] = m_stg[1];
        end else if (p == 3'd3) begin
            m_out[0] = v;
            m_out[1] = v;
        end else if (p == 3'd4) begin
            m_out[0] = m_stg[0];
            m_out[1] = m_stg[1];
        end else if (p == 3'd0) begin
            if (v[11:9] == 3'b001) m_out[0] = m_stg[0];
            else if (v[11:9] == 3'b101) m_out[1] = m_stg[1];
            else if (v[11:9] == 3'b010) m_pin = 1'b0;
            else if (v[11:9] == 3'b011) m_pin = 1'b1;
            else if (v[11:8] == 4'b1001) m_mode = 1'b1;
            else if (v[11:8] == 4'b1000) m_mode = 1'b0;
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_stg[0] = '0; m_stg[1] = '0; m_out[0] = '0; m_out[1] = '0;
            m_pin = 1'b0; m_mode = 1'b0;
            e1_clr = 0; e2_clr = 0; e1_cm = 0; e2_cm = 0; e1_w = '0; e2_w = '0;
            cur_commit = 0;
        end else begin
            if (e2_clr) begin
                m_stg[0] = '0; m_stg[1] = '0; m_out[0] = '0; m_out[1] = '0;
            end else if (e2_cm) begin
                model_apply(e2_w);
            end
            e2_clr = e1_clr; e2_cm = e1_cm; e2_w = e1_w;
            e1_clr = !clr_n; e1_cm = cur_commit; e1_w = cur_word;
            cur_commit = 0;
        end
    end

    // R12: every-cycle comparison against the timed model
    always @(negedge clk) begin
        if (started && rst_n) begin
            checks++;
            if (chan_a_o !== m_out[0] || chan_b_o !== m_out[1] ||
                user_pin_o !== m_pin || edge_mode_o !== m_mode) begin
                failures++;
                $display("FAIL R12 model cycle: act a=%h b=%h pin=%b mode=%b exp a=%h b=%h pin=%b mode=%b",
                         chan_a_o, chan_b_o, user_pin_o, edge_mode_o,
                         m_out[0], m_out[1], m_pin, m_mode);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic chk_out(input string tag, input int a, input int b);
        chk(tag, int'(chan_a_o), a);
        chk(tag, int'(chan_b_o), b);
    endtask

    function automatic logic [15:0] mk(input logic [2:0] p, input logic [11:0] v);
        return {p, v, 1'b0};
    endfunction

    task automatic send_frame(input logic [15:0] w, input int n);
        @(negedge clk);
        ser_csn = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            ser_din = (i < 16) ? w[15-i] : 1'b0;
            ser_clk = 1'b0;
            repeat (3) @(negedge clk);
            ser_clk = 1'b1;
            repeat (3) @(negedge clk);
        end
        ser_clk = 1'b0;
        repeat (3) @(negedge clk);
        ser_csn = 1'b1;
        if (n == 16) begin
            cur_word = w;
            cur_commit = 1;
        end
    endtask

    task automatic send(input logic [15:0] w);
        send_frame(w, 16);
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: act=timeout exp=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        started = 1;
        @(negedge clk);
        // R10 reset state
        chk_out("R10 reset outputs", 0, 0);
        chk("R10 reset pin", int'(user_pin_o), 0);
        chk("R10 reset mode", int'(edge_mode_o), 0);

        // R3 staging-only loads
        send(mk(3'b001, 12'hABC));
        chk_out("R3 load A keeps outputs", 0, 0);
        send(mk(3'b101, 12'h123));
        chk_out("R3 load B keeps outputs", 0, 0);

        // R6 transfer, R1 bit order shows in values
        send(mk(3'b100, 12'h000));
        chk_out("R6 transfer", 'hABC, 'h123);
        chk("R1 MSB-first value", int'(chan_a_o), 'hABC);

        // R4 load with update
        send(mk(3'b010, 12'h555));
        chk_out("R4 load A update", 'h555, 'h123);
        send(mk(3'b110, 12'h0F0));
        chk_out("R4 load B update", 'h555, 'h0F0);

        // R5 direct write, staging untouched
        send(mk(3'b011, 12'hFFF));
        chk_out("R5 direct", 'hFFF, 'hFFF);
        send(mk(3'b100, 12'h000));
        chk_out("R5 staging unchanged", 'h555, 'h0F0);

        // R7 single-channel transfers
        send(mk(3'b001, 12'h111));
        send(mk(3'b000, 12'h200));
        chk_out("R7 transfer A only", 'h111, 'h0F0);
        send(mk(3'b101, 12'h222));
        send(mk(3'b000, 12'hA00));
        chk_out("R7 transfer B only", 'h111, 'h222);

        // R8 pin and mode
        send(mk(3'b000, 12'h600));
        chk("R8 pin high", int'(user_pin_o), 1);
        send(mk(3'b000, 12'h400));
        chk("R8 pin low", int'(user_pin_o), 0);
        send(mk(3'b000, 12'h700));
        chk("R8 pin high again", int'(user_pin_o), 1);
        send(mk(3'b000, 12'h900));
        chk("R8 mode 1", int'(edge_mode_o), 1);
        send(mk(3'b000, 12'h800));
        chk("R8 mode 0", int'(edge_mode_o), 0);
        send(mk(3'b000, 12'h900));
        send(mk(3'b000, 12'h100));
        send(mk(3'b111, 12'h3C3));
        send(mk(3'b000, 12'hC00));
        chk_out("R8 no-op keeps outputs", 'h111, 'h222);
        chk("R8 no-op keeps mode", int'(edge_mode_o), 1);
        chk("R8 no-op keeps pin", int'(user_pin_o), 1);

        // R11 wrong bit counts discarded
        send_frame(mk(3'b011, 12'h3C3), 15);
        repeat (8) @(negedge clk);
        chk_out("R11 15-bit frame dropped", 'h111, 'h222);
        send_frame(mk(3'b011, 12'h3C3), 17);
        repeat (8) @(negedge clk);
        chk_out("R11 17-bit frame dropped", 'h111, 'h222);

        // R2 activity with select high ignored
        for (int i = 0; i < 20; i++) begin
            ser_din = i[0];
            ser_clk = 1'b1;
            repeat (3) @(negedge clk);
            ser_clk = 1'b0;
            repeat (3) @(negedge clk);
        end
        chk_out("R2 idle clocks ignored", 'h111, 'h222);
        send(mk(3'b011, 12'h0A5));
        chk_out("R2 next frame intact", 'h0A5, 'h0A5);

        // R12 latency of a commit
        send_frame(mk(3'b011, 12'h5A5), 16);
        repeat (2) @(negedge clk);
        chk("R12 not yet at edge 2", int'(chan_a_o), 'h0A5);
        @(negedge clk);
        chk("R12 due at edge 3", int'(chan_a_o), 'h5A5);
        repeat (8) @(negedge clk);

        // R9 clear zeroes data, keeps pin and mode
        send(mk(3'b001, 12'h777));
        send(mk(3'b101, 12'h888));
        @(negedge clk);
        clr_n = 1'b0;
        repeat (4) @(negedge clk);
        clr_n = 1'b1;
        repeat (4) @(negedge clk);
        chk_out("R9 clear outputs", 0, 0);
        chk("R9 clear keeps pin", int'(user_pin_o), 1);
        chk("R9 clear keeps mode", int'(edge_mode_o), 1);
        send(mk(3'b100, 12'h000));
        chk_out("R9 clear staging", 0, 0);

        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule